// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt causes of a multi-channel DMA engine and presents them to software. The transfer engine pulses one strobe per channel for each event it detects: a bus error, a finished transfer or a freshly loaded descriptor. It also holds a level for each channel that is parked in the stopped or uninitialized state. Each channel owns a control/status register. That register holds three sticky event flags, a read-only copy of the stopped level and three interrupt enables.

A read-only summary word shows one pending bit per channel, and a single interrupt line is raised toward the processor. Software reads the summary to find the channel that needs service. It then reads that channel's register and writes the same value back. Because the flags are write-one-to-clear, this acknowledges exactly the events it has seen and leaves the enables unchanged.

The register port is a plain single-cycle interface. Channel n's register sits at address n, and the summary sits at address NCH. Reads are combinational and writes take effect on the clock edge.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every channel register reads 0 (all flags and enables clear), the summary reads 0 and `irq` is low.
- R2: The summary word at address NCH shows channel n's pending state in bit n. Bits above NCH-1 read 0, and a write to this address changes nothing.
- R3: An `ev_err` strobe on channel n sets that channel's error flag (register bit 0) on the next clock edge, regardless of any enable. The channel then becomes pending.
- R4: An `ev_end` strobe sets the done flag (bit 1) only while the done enable (bit 4) is 1. With the enable at 0 the strobe leaves bit 1 at 0 and the summary unchanged.
- R5: An `ev_start` strobe sets the loaded flag (bit 2) only while the load enable (bit 5) is 1. With the enable at 0 the strobe leaves bit 2 at 0.
- R6: Register bit 3 reads the channel's `ch_stopped` level, and writes do not affect it. While bit 3 and the stop enable (bit 6) are both 1, the channel is pending in the same cycle. Pending ends as soon as either one drops, with no write needed.
- R7: Writing 1 to bit 0, 1 or 2 clears that flag, and writing 0 to it leaves the flag as it is. Writing back a value just read clears exactly the flags that were set, keeps the enables, and leaves any active stop condition pending.
- R8: If a strobe and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when at least one summary bit is high.
- R10: Bits 4, 5 and 6 are plain read/write enables that return the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | AW | Register address: channel n at n, summary at NCH |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| ev_err | input | NCH | Per-channel bus error strobe |
| ev_end | input | NCH | Per-channel transfer-done strobe |
| ev_start | input | NCH | Per-channel descriptor-loaded strobe |
| ch_stopped | input | NCH | Per-channel stopped/uninitialized level |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with its defaults: 16 channels, 32-bit data and a 5-bit address. With these values both edge channels, 0 and 15, are reachable. The summary address sits just past the last channel, so the bench can check that the reserved upper half of the summary reads zero. It can also confirm that a pending event on the highest channel reaches bit 15 and the interrupt line.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] ev_err,
  input  logic [NCH-1:0] ev_end,
  input  logic [NCH-1:0] ev_start,
  input  logic [NCH-1:0] ch_stopped,
  output logic           irq
);
  localparam int PADW = DW - 7;

  logic [NCH-1:0] err_q, end_q, sta_q;
  logic [NCH-1:0] end_en, sta_en, stp_en;
  logic [NCH-1:0] pend;
  logic [DW-1:0]  chreg [NCH];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = we && (addr == AW'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_q[n]  <= 1'b0;
        end_q[n]  <= 1'b0;
        sta_q[n]  <= 1'b0;
        end_en[n] <= 1'b0;
        sta_en[n] <= 1'b0;
        stp_en[n] <= 1'b0;
      end else begin
        err_q[n] <= ev_err[n] | (err_q[n] & ~(hit & wdata[0]));
        end_q[n] <= (ev_end[n] & end_en[n]) | (end_q[n] & ~(hit & wdata[1]));
        sta_q[n] <= (ev_start[n] & sta_en[n]) | (sta_q[n] & ~(hit & wdata[2]));
        if (hit) begin
          end_en[n] <= wdata[4];
          sta_en[n] <= wdata[5];
          stp_en[n] <= wdata[6];
        end
      end
    end

    assign pend[n]  = err_q[n] | end_q[n] | sta_q[n] | (stp_en[n] & ch_stopped[n]);
    assign chreg[n] = {{PADW{1'b0}}, stp_en[n], sta_en[n], end_en[n],
                       ch_stopped[n], sta_q[n], end_q[n], err_q[n]};
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(NCH)) rdata[NCH-1:0] = pend;
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(i)) rdata = chreg[i];
  end

  assign irq = |pend;
endmodule

module dma_irq_agg_chk #(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           we,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  wdata,
  input logic [NCH-1:0] ev_err,
  input logic [NCH-1:0] ev_end,
  input logic [NCH-1:0] ch_stopped,
  input logic [NCH-1:0] err_q,
  input logic [NCH-1:0] end_q,
  input logic [NCH-1:0] end_en,
  input logic [NCH-1:0] stp_en,
  input logic           irq
);
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err != '0) |=> ((err_q & $past(ev_err)) == $past(ev_err)));

  // R4
  end_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((end_q & ~$past(end_q) & ~$past(ev_end & end_en)) == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_p
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[n] && !(we && addr == AW'(n) && wdata[0])) |=> err_q[n]);

    // R6
    stop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_stopped[n] && stp_en[n]) |-> irq);
  end
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
  localparam int PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NCH-1:0] ev_err = '0, ev_end = '0, ev_start = '0, ch_stopped = '0;
  logic irq;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_irq_agg u_dut (.clk, .rst_n, .we, .addr, .wdata, .rdata,
    .ev_err, .ev_end, .ev_start, .ch_stopped, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr = AW'(a); #1 v = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3, v);  chk("R1 ch3 reg", v, 0);
    rd(15, v); chk("R1 ch15 reg", v, 0);
    rd(NCH, v); chk("R1 summary", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_error;
    logic [31:0] v;
    @(negedge clk); ev_err[0] = 1; ev_err[15] = 1;
    @(negedge clk); ev_err = '0;
    rd(0, v); chk("R3 ch0 err flag", v, 32'h1);
    rd(NCH, v); chk("R2 summary bits", v, 32'h0000_8001);
    chk("R9 irq high", irq, 1);
    wr(NCH, 32'hFFFF_FFFF);
    rd(NCH, v); chk("R2 summary ro", v, 32'h0000_8001);
    wr(0, 32'h1); wr(15, 32'h1);
    rd(NCH, v); chk("R7 cleared", v, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_end_start;
    logic [31:0] v;
    @(negedge clk); ev_end[2] = 1; ev_start[2] = 1;
    @(negedge clk); ev_end = '0; ev_start = '0;
    rd(2, v); chk("R4/R5 gated off", v, 0);
    rd(NCH, v); chk("R4 summary unchanged", v, 0);
    wr(2, 32'h10);
    rd(2, v); chk("R10 end enable", v, 32'h10);
    @(negedge clk); ev_end[2] = 1; ev_start[2] = 1;
    @(negedge clk); ev_end = '0; ev_start = '0;
    rd(2, v); chk("R4 done flag", v, 32'h12);
    wr(2, 32'h32);
    @(negedge clk); ev_start[2] = 1;
    @(negedge clk); ev_start = '0;
    rd(2, v); chk("R5 load flag", v, 32'h34);
    wr(2, 32'h4);
    rd(2, v); chk("R7 clear load only", v, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    @(negedge clk); ch_stopped[7] = 1;
    #1 chk("R6 no enable", irq, 0);
    rd(7, v); chk("R6 level bit", v, 32'h8);
    wr(7, 32'h40);
    #1 chk("R6 pending", irq, 1);
    rd(NCH, v); chk("R6 summary", v, 32'h80);
    @(negedge clk); ch_stopped[7] = 0;
    #1 chk("R6 drop on leave", irq, 0);
    wr(7, 32'h0);
  endtask

  task automatic t_writeback;
    logic [31:0] v;
    wr(3, 32'h60);
    @(negedge clk); ev_err[3] = 1; ev_start[3] = 1; ch_stopped[3] = 1;
    @(negedge clk); ev_err = '0; ev_start = '0;
    rd(3, v); chk("R7 read", v, 32'h6D);
    wr(3, 32'h0000_0068);
    rd(3, v); chk("R7 zero write no effect", v, 32'h6D);
    wr(3, 32'h6D);
    rd(3, v); chk("R7 write back", v, 32'h68);
    chk("R7 stop still pending", irq, 1);
    @(negedge clk); ch_stopped[3] = 0;
    wr(3, 32'h0);
    chk("R7 idle", irq, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk); ev_err[9] = 1;
    @(negedge clk); ev_err = '0;
    @(negedge clk); ev_err[9] = 1; we = 1; addr = AW'(9); wdata = 32'h1;
    @(negedge clk); ev_err = '0; we = 0; wdata = '0;
    rd(9, v); chk("R8 set wins", v, 32'h1);
    wr(9, 32'h1);
    rd(9, v); chk("R8 later clear", v, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_error();
    t_end_start();
    t_stop();
    t_writeback();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule